// File: doc/BRIEF.md
# Clock Ratio and Reset Sequencer

This block runs on the internal core clock. It produces a one-cycle bus-clock enable, `bus_edge_en`, which marks each edge of the slower external master clock. A two-bit strap sets the number of core cycles per bus period. Three ratios are whole numbers. The fourth is the fractional ratio of two and a half, which the block builds by alternating periods of two and three core cycles.

The block also sequences the internal core reset from three inputs: a cold (power-up) reset, a warm reset and a PLL enable. It counts how long each reset input is held, in bus-clock edges. If a reset input is released too early, the block raises a sticky error flag and keeps the core in reset until the full minimum count has elapsed. After a cold reset, the PLL is modelled as a lock counter of core cycles, and the core leaves reset only once that count completes. The ratio strap is latched while cold reset is held. The endian strap is latched while either reset is held.

All inputs are treated as synchronous to the core clock. At power-up, `pll_enable` must be held low together with `cold_rst_n` for at least one clock. This puts the phase and lock counters in a known state.

Top module: `ratio_reset_seq`

## Requirements
- R1: Ratio codes: `00` gives 4 core cycles per bus period, `10` gives 2 and `11` gives 3. `bus_edge_en` is high for exactly one core cycle per bus period.
- R2: Ratio code `01` gives bus periods that alternate between 2 and 3 core cycles, so any four consecutive periods span 10 core cycles.
- R3: `ratio_code` follows `ratio_sel` only in cycles where `cold_rst_n` is low. Changes to `ratio_sel` at any other time have no effect.
- R4: When `cold_rst_n` is released after more than COLD_MIN bus edges have been counted, `seq_err` stays 0 and the sequencer goes on to the lock phase.
- R5: When `cold_rst_n` is released with COLD_MIN or fewer bus edges counted, `seq_err` becomes 1. The core stays in reset until more than COLD_MIN bus edges have been counted and the lock phase has then completed.
- R6: After a cold reset completes, `pll_locked` rises LOCK_CYCLES core cycles later, and `core_rst_n` rises one cycle after that.
- R7: While `pll_enable` is 0, `bus_edge_en` and `pll_locked` are 0 and the core is held in reset. When `pll_enable` returns to 1, a fresh lock count of LOCK_CYCLES runs before `core_rst_n` rises.
- R8: When `warm_rst_n` goes low while the core is running, `core_rst_n` drops on the next cycle. If it is released after more than WARM_MIN bus edges, `core_rst_n` rises one cycle after the release, with no error.
- R9: When `warm_rst_n` is released with WARM_MIN or fewer bus edges counted, `seq_err` becomes 1. The core stays in reset until the count exceeds WARM_MIN.
- R10: `big_endian` captures `endian_sel` (1 = big endian, 0 = little endian) while either reset input is low, and ignores it otherwise.
- R11: `cold_rst_n` low overrides every other input. It clears `seq_err` and starts a new cold count, even in the same cycle as a warm release.
- R12: Once set, `seq_err` stays 1 until `cold_rst_n` is next driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Cold reset, active low |
| warm_rst_n | input | 1 | Warm reset, active low |
| pll_enable | input | 1 | PLL run control; 0 halts the modelled PLL |
| ratio_sel | input | 2 | Core-to-bus ratio strap |
| endian_sel | input | 1 | Endian strap, 1 = big endian |
| bus_edge_en | output | 1 | One-cycle pulse per bus-clock edge |
| core_rst_n | output | 1 | Internal core reset, active low |
| pll_locked | output | 1 | Modelled PLL lock flag |
| ratio_code | output | 2 | Latched ratio strap |
| big_endian | output | 1 | Latched endian setting |
| seq_err | output | 1 | Sticky flag for a reset pulse that was too short |

## Verification
A cold-reset assertion and a warm-reset release can land on the same clock edge. The warm release alone would return the core to run; the cold assertion must win. The bench provokes this by holding warm reset for a full count and then, at one sampling point, driving warm high and cold low together. The result is judged correct when `core_rst_n` stays low, `seq_err` reads 0, and an immediate short cold release then sets the error and stretches the reset past the lock time.

// File: rtl/ratio_reset_seq_pkg.sv
package ratio_reset_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_COLD = 2'd0,
    SEQ_LOCK = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_WARM = 2'd3
  } seq_state_e;

  // ratio strap encodings (core cycles per bus period)
  localparam logic [1:0] RATIO_X4   = 2'b00;
  localparam logic [1:0] RATIO_X2P5 = 2'b01;
  localparam logic [1:0] RATIO_X2   = 2'b10;
  localparam logic [1:0] RATIO_X3   = 2'b11;

  localparam int PHASE_W = 3;

endpackage

// File: rtl/rrs_ratio_gen.sv
module rrs_ratio_gen
  import ratio_reset_seq_pkg::*;
(
  input  logic       clk,
  input  logic       pll_run,
  input  logic [1:0] ratio,
  output logic       edge_en
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] last_phase;
  logic               long_q;
  logic               run_q;

  // final phase index of the current bus period
  always_comb begin
    case (ratio)
      RATIO_X4:   last_phase = PHASE_W'(3);
      RATIO_X2P5: last_phase = long_q ? PHASE_W'(2) : PHASE_W'(1);
      RATIO_X2:   last_phase = PHASE_W'(1);
      default:    last_phase = PHASE_W'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    run_q <= pll_run;
    if (!pll_run) begin
      phase_q <= '0;
      long_q  <= 1'b0;
    end else if (phase_q >= last_phase) begin
      phase_q <= '0;
      if (ratio == RATIO_X2P5) long_q <= ~long_q;
    end else begin
      phase_q <= phase_q + PHASE_W'(1);
    end
  end

  assign edge_en = run_q && (phase_q == '0);

endmodule

// File: rtl/rrs_min_count.sv
module rrs_min_count #(
  parameter int LIMIT = 17
) (
  input  logic clk,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) cnt_q <= '0;
    else if (inc && !done) cnt_q <= cnt_q + CW'(1);
  end

  assign done = (cnt_q == LIM_V);

endmodule

// File: rtl/rrs_seq_fsm.sv
module rrs_seq_fsm
  import ratio_reset_seq_pkg::*;
(
  input  logic       clk,
  input  logic       cold_n,
  input  logic       warm_n,
  input  logic       pll_run,
  input  logic       cold_done,
  input  logic       warm_done,
  input  logic       lock_done,
  output seq_state_e state,
  output logic       err
);

  seq_state_e state_q;
  logic       err_q;

  always_ff @(posedge clk) begin
    if (!cold_n) begin
      state_q <= SEQ_COLD;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_COLD: begin
          if (cold_done) state_q <= SEQ_LOCK;
          else           err_q   <= 1'b1;
        end
        SEQ_LOCK: if (lock_done) state_q <= SEQ_RUN;
        SEQ_RUN: begin
          if (!pll_run)     state_q <= SEQ_LOCK;
          else if (!warm_n) state_q <= SEQ_WARM;
        end
        default: begin
          if (!pll_run) state_q <= SEQ_LOCK;
          else if (warm_n) begin
            if (warm_done) state_q <= SEQ_RUN;
            else           err_q   <= 1'b1;
          end
        end
      endcase
    end
  end

  assign state = state_q;
  assign err   = err_q;

endmodule

// File: rtl/ratio_reset_seq.sv
module ratio_reset_seq
  import ratio_reset_seq_pkg::*;
#(
  parameter int COLD_MIN    = 64000,
  parameter int WARM_MIN    = 16,
  parameter int LOCK_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       warm_rst_n,
  input  logic       pll_enable,
  input  logic [1:0] ratio_sel,
  input  logic       endian_sel,
  output logic       bus_edge_en,
  output logic       core_rst_n,
  output logic       pll_locked,
  output logic [1:0] ratio_code,
  output logic       big_endian,
  output logic       seq_err
);

  localparam int COLD_LIM = COLD_MIN + 1;
  localparam int WARM_LIM = WARM_MIN + 1;

  seq_state_e state;
  logic [1:0] ratio_q;
  logic       endian_q;
  logic       cold_done, warm_done, lock_done;

  // straps: ratio only under cold reset, endian under either reset
  always_ff @(posedge clk) begin
    if (!cold_rst_n) ratio_q <= ratio_sel;
    if (!cold_rst_n || !warm_rst_n) endian_q <= endian_sel;
  end

  rrs_ratio_gen u_ratio (
    .clk     (clk),
    .pll_run (pll_enable),
    .ratio   (ratio_q),
    .edge_en (bus_edge_en)
  );

  rrs_min_count #(.LIMIT(COLD_LIM)) u_cold_cnt (
    .clk  (clk),
    .clr  (!pll_enable || (state != SEQ_COLD)),
    .inc  (bus_edge_en),
    .done (cold_done)
  );

  rrs_min_count #(.LIMIT(WARM_LIM)) u_warm_cnt (
    .clk  (clk),
    .clr  (state != SEQ_WARM),
    .inc  (bus_edge_en),
    .done (warm_done)
  );

  rrs_min_count #(.LIMIT(LOCK_CYCLES)) u_lock_cnt (
    .clk  (clk),
    .clr  (!pll_enable || (state == SEQ_COLD)),
    .inc  (1'b1),
    .done (lock_done)
  );

  rrs_seq_fsm u_fsm (
    .clk       (clk),
    .cold_n    (cold_rst_n),
    .warm_n    (warm_rst_n),
    .pll_run   (pll_enable),
    .cold_done (cold_done),
    .warm_done (warm_done),
    .lock_done (lock_done),
    .state     (state),
    .err       (seq_err)
  );

  assign core_rst_n = (state == SEQ_RUN);
  assign pll_locked = lock_done;
  assign ratio_code = ratio_q;
  assign big_endian = endian_q;

endmodule

// File: rtl/ratio_reset_seq_chk.sv
module ratio_reset_seq_chk (
  input logic       clk,
  input logic       cold_rst_n,
  input logic       warm_rst_n,
  input logic       pll_enable,
  input logic       bus_edge_en,
  input logic       core_rst_n,
  input logic       pll_locked,
  input logic [1:0] ratio_code,
  input logic       big_endian,
  input logic       seq_err
);

  // R1: an enable pulse never lasts two cycles (shortest period is 2)
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    bus_edge_en |=> !bus_edge_en);

  // R3: latched ratio holds while cold reset is released
  p_ratio_hold_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cold_rst_n |=> $stable(ratio_code));

  // R6: the core never runs without lock
  p_core_needs_lock_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    core_rst_n |-> pll_locked);

  // R7: a halted PLL stops the enable and drops lock
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !pll_enable |=> (!bus_edge_en && !pll_locked));

  // R8: warm reset takes the core down on the next cycle
  p_warm_enter_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (core_rst_n && !warm_rst_n && pll_enable) |=> !core_rst_n);

  // R10: endian holds while neither reset is low
  p_endian_hold_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst_n |=> $stable(big_endian));

  // R12: error flag is sticky outside cold reset
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!cold_rst_n)
    seq_err |=> seq_err);

endmodule

bind ratio_reset_seq ratio_reset_seq_chk chk_i (
  .clk         (clk),
  .cold_rst_n  (cold_rst_n),
  .warm_rst_n  (warm_rst_n),
  .pll_enable  (pll_enable),
  .bus_edge_en (bus_edge_en),
  .core_rst_n  (core_rst_n),
  .pll_locked  (pll_locked),
  .ratio_code  (ratio_code),
  .big_endian  (big_endian),
  .seq_err     (seq_err)
);

// File: tb/ratio_reset_seq_tb_top.sv
`timescale 1ns/1ps
module ratio_reset_seq_tb_top;

  localparam int COLD_MIN = 12;
  localparam int WARM_MIN = 4;
  localparam int LOCK_CYC = 20;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] total;
    logic [3:0] lo;
    logic [3:0] hi;
    logic       alt;
  } vec_t;

  // four bus periods per row: expected span, shortest, longest, alternation
  localparam vec_t VECS [4] = '{
    '{2'b00, 8'd16, 4'd4, 4'd4, 1'b0},
    '{2'b01, 8'd10, 4'd2, 4'd3, 1'b1},
    '{2'b10, 8'd8,  4'd2, 4'd2, 1'b0},
    '{2'b11, 8'd12, 4'd3, 4'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic cold_rst_n, warm_rst_n, pll_enable, endian_sel;
  logic [1:0] ratio_sel;
  logic bus_edge_en, core_rst_n, pll_locked, big_endian, seq_err;
  logic [1:0] ratio_code;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  ratio_reset_seq #(.COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN), .LOCK_CYCLES(LOCK_CYC)) dut_i (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .pll_enable(pll_enable), .ratio_sel(ratio_sel), .endian_sel(endian_sel),
    .bus_edge_en(bus_edge_en), .core_rst_n(core_rst_n), .pll_locked(pll_locked),
    .ratio_code(ratio_code), .big_endian(big_endian), .seq_err(seq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // wait until n enable pulses are counted, plus the edge that counts the last
  task automatic hold_pulses(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (bus_edge_en) seen++;
    end
    @(negedge clk);
  endtask

  task automatic cold_seq(input logic [1:0] sel, input logic endian);
    cold_rst_n = 1'b0;
    ratio_sel  = sel;
    endian_sel = endian;
    hold_pulses(COLD_MIN + 1);
    cold_rst_n = 1'b1;
    @(negedge clk);
    chk("R4 no error after full cold", int'(seq_err), 0);
    repeat (LOCK_CYC - 1) @(negedge clk);
    chk("R6 lock not yet", int'(pll_locked), 0);
    @(negedge clk);
    chk("R6 lock raised", int'(pll_locked), 1);
    chk("R6 core still in reset", int'(core_rst_n), 0);
    @(negedge clk);
    chk("R6 core released", int'(core_rst_n), 1);
  endtask

  task automatic wait_core(input int limit, output int took);
    took = 0;
    while (!core_rst_n && took < limit) begin
      @(negedge clk);
      took++;
    end
  endtask

  task automatic measure(output int tot, output int lo, output int hi, output bit alt_ok);
    int prev = 0;
    int guard = 0;
    tot = 0; lo = 99; hi = 0; alt_ok = 1'b1;
    while (!bus_edge_en && guard < 16) begin
      @(negedge clk);
      guard++;
    end
    for (int k = 0; k < 4; k++) begin
      int len = 0;
      do begin
        @(negedge clk);
        len++;
      end while (!bus_edge_en && len < 16);
      tot += len;
      if (len < lo) lo = len;
      if (len > hi) hi = len;
      if (k > 0 && len == prev) alt_ok = 1'b0;
      prev = len;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int tot, lo, hi, took;
    bit alt_ok;
    cold_rst_n = 1'b0; warm_rst_n = 1'b1; pll_enable = 1'b0;
    ratio_sel = 2'b00; endian_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R11 / R7 power-up state
    chk("R11 reset core", int'(core_rst_n), 0);
    chk("R11 reset err", int'(seq_err), 0);
    chk("R7 reset lock", int'(pll_locked), 0);
    chk("R7 reset enable", int'(bus_edge_en), 0);
    chk("R10 endian captured", int'(big_endian), 1);
    pll_enable = 1'b1;
    cold_seq(2'b00, 1'b1);

    // R3 / R10 straps ignored while running
    ratio_sel = 2'b11; endian_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 ratio ignored", int'(ratio_code), 0);
    chk("R10 endian ignored", int'(big_endian), 1);

    // ratio table (R1, R2)
    for (int i = 0; i < 4; i++) begin
      cold_seq(VECS[i].sel, 1'b1);
      chk("R3 ratio latched", int'(ratio_code), int'(VECS[i].sel));
      measure(tot, lo, hi, alt_ok);
      if (VECS[i].alt) begin
        chk("R2 span", tot, int'(VECS[i].total));
        chk("R2 shortest", lo, int'(VECS[i].lo));
        chk("R2 longest", hi, int'(VECS[i].hi));
        chk("R2 alternation", int'(alt_ok), 1);
      end else begin
        chk("R1 span", tot, int'(VECS[i].total));
        chk("R1 shortest", lo, int'(VECS[i].lo));
        chk("R1 longest", hi, int'(VECS[i].hi));
      end
    end

    // R8 warm reset of full length, endian recaptured
    warm_rst_n = 1'b0; endian_sel = 1'b0;
    @(negedge clk);
    chk("R8 core down", int'(core_rst_n), 0);
    hold_pulses(WARM_MIN + 1);
    warm_rst_n = 1'b1;
    @(negedge clk);
    chk("R8 core back", int'(core_rst_n), 1);
    chk("R8 no error", int'(seq_err), 0);
    chk("R10 endian from warm", int'(big_endian), 0);

    // R9 short warm reset
    warm_rst_n = 1'b0;
    hold_pulses(WARM_MIN);
    warm_rst_n = 1'b1;
    @(negedge clk);
    chk("R9 error set", int'(seq_err), 1);
    chk("R9 reset extended", int'(core_rst_n), 0);
    wait_core(16, took);
    chk("R9 released after extension", int'(core_rst_n), 1);
    repeat (10) @(negedge clk);
    chk("R12 error sticky", int'(seq_err), 1);

    // R7 PLL halt and relock
    pll_enable = 1'b0;
    @(negedge clk);
    chk("R7 core down", int'(core_rst_n), 0);
    chk("R7 lock down", int'(pll_locked), 0);
    tot = 0;
    repeat (6) begin
      @(negedge clk);
      if (bus_edge_en) tot++;
    end
    chk("R7 no enable while halted", tot, 0);
    pll_enable = 1'b1;
    repeat (LOCK_CYC - 1) @(negedge clk);
    chk("R7 relock pending", int'(pll_locked), 0);
    @(negedge clk);
    chk("R7 relocked", int'(pll_locked), 1);
    @(negedge clk);
    chk("R7 core back", int'(core_rst_n), 1);

    // R11 collision: warm release and cold assert on the same edge
    warm_rst_n = 1'b0;
    hold_pulses(WARM_MIN + 1);
    warm_rst_n = 1'b1; cold_rst_n = 1'b0;
    @(negedge clk);
    chk("R11 cold wins", int'(core_rst_n), 0);
    chk("R11 error cleared", int'(seq_err), 0);
    cold_rst_n = 1'b1;
    @(negedge clk);
    chk("R5 short cold error", int'(seq_err), 1);
    wait_core(400, took);
    chk("R5 extension long enough", int'(took > LOCK_CYC + 2 * COLD_MIN), 1);
    chk("R5 core eventually released", int'(core_rst_n), 1);

    // R5 exact boundary: COLD_MIN pulses is too short
    cold_rst_n = 1'b0;
    hold_pulses(COLD_MIN);
    cold_rst_n = 1'b1;
    @(negedge clk);
    chk("R5 boundary error", int'(seq_err), 1);
    chk("R5 boundary core held", int'(core_rst_n), 0);
    wait_core(400, took);
    chk("R5 boundary released", int'(core_rst_n), 1);

    // R11 / R12 a full cold reset clears the error
    cold_seq(2'b10, 1'b1);
    chk("R12 error cleared by cold", int'(seq_err), 0);
    chk("R10 endian big", int'(big_endian), 1);

    finish_run();
  end

endmodule